// File: doc/BRIEF.md
# SPI Interrupt and Mode-Fault Controller

This block sits beside an SPI port and decides when the port's single interrupt line goes high. In core-driven operation (DMA off) the interrupt follows the data buffers: it is raised while the receive buffer holds data or the transmit buffer has room. In DMA operation the interrupt comes from sticky status flags. A transfer interrupt is taken either on the DMA engine's internal count reaching zero or on completion of the external transfer, chosen by a select bit. An error interrupt is taken on a multimaster fault, or on an underflow or overflow that matches the configured direction.

The block also guards against a second master on the bus. When fault detection is enabled and the port is master, the block samples the active-low slave-select input through a two-flop synchronizer. The first synchronized low sample records a fault and demotes the port to slave in that same clock edge. Status flags are cleared by software writing ones to them. The interrupt output is registered and gated by a port-wide enable.

Top module: `spi_irq_fault_ctrl`

## Requirements
- R1: After synchronous reset, `irq_o` is 0, all four `status_o` bits are 0 and `master_o` is 0 (slave).
- R2: With `cfg_dma_en`=0 and `cfg_irq_gate`=1, `irq_o` becomes `rx_not_empty | tx_not_full` one clock after those inputs are presented.
- R3: With `cfg_dma_en`=0, underflow and overflow pulses still set `status_o[1]` and `status_o[2]`, but they never raise `irq_o`.
- R4: With `cfg_dma_en`=1, `cfg_xfer_irq_en`=1 and `cfg_done_sel`=0, a `dma_count_zero` pulse sets the transfer-done flag `status_o[3]` and raises `irq_o` on the same edge; a `dma_ext_done` pulse has no effect.
- R5: With `cfg_done_sel`=1, a `dma_ext_done` pulse sets `status_o[3]` and raises `irq_o`; a `dma_count_zero` pulse has no effect.
- R6: In DMA mode with `cfg_err_irq_en`=1, a recorded underflow (`status_o[1]`) raises `irq_o` only when `cfg_dir_rx`=0 (transmit).
- R7: In DMA mode with `cfg_err_irq_en`=1, a recorded overflow (`status_o[2]`) raises `irq_o` only when `cfg_dir_rx`=1 (receive).
- R8: With `cfg_fault_det_en`=1 and `master_o`=1, a low on `ss_n_in` held from one falling clock edge sets the fault flag `status_o[0]` and clears `master_o` on the third rising edge that follows. In DMA mode with `cfg_err_irq_en`=1 this also raises `irq_o`.
- R9: With `cfg_fault_det_en`=0, a low on `ss_n_in` changes neither `master_o` nor `status_o[0]`.
- R10: Each status bit stays set until a 1 is written to the matching `sw_clr` bit. A set event in the same cycle as the clear leaves the bit set.
- R11: `sw_wr_master` loads `sw_master_val` into `master_o` on the next edge, except when a fault is detected on that edge, in which case `master_o` becomes 0.
- R12: While `cfg_irq_gate`=0, `irq_o` is 0 one clock later whatever the flags hold. The flags are kept, and the interrupt returns one clock after the gate reopens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_dma_en | input | 1 | 1 = DMA-driven, 0 = core-driven |
| cfg_xfer_irq_en | input | 1 | Enable transfer-done interrupt in DMA mode |
| cfg_done_sel | input | 1 | 0 = internal count zero, 1 = external transfer done |
| cfg_err_irq_en | input | 1 | Enable error interrupt in DMA mode |
| cfg_dir_rx | input | 1 | 1 = receive, 0 = transmit |
| cfg_fault_det_en | input | 1 | Enable multimaster fault detection |
| cfg_irq_gate | input | 1 | Port-wide interrupt enable (1 = allowed) |
| dma_count_zero | input | 1 | Pulse: DMA internal count reached zero |
| dma_ext_done | input | 1 | Pulse: external transfer completed |
| rx_not_empty | input | 1 | Receive buffer holds data |
| tx_not_full | input | 1 | Transmit buffer has room |
| tx_underflow | input | 1 | Pulse: transmit underflow |
| rx_overflow | input | 1 | Pulse: receive overflow |
| ss_n_in | input | 1 | Asynchronous active-low slave-select input |
| sw_wr_master | input | 1 | Software write strobe for the master bit |
| sw_master_val | input | 1 | Value written to the master bit |
| sw_clr | input | 4 | Write-one-to-clear strobes, same bit order as `status_o` |
| irq_o | output | 1 | Registered interrupt |
| status_o | output | 4 | [0] fault, [1] underflow, [2] overflow, [3] transfer done |
| master_o | output | 1 | 1 = master, 0 = slave |

## Verification
On every cycle the assertions check four things. A fault flag only rises while the port was master, and the port is slave on that same cycle. A status bit that was set and not cleared stays set. A closed gate forces the interrupt low one cycle later, and in core mode a buffer request raises it one cycle later. The direction qualification of errors, the choice between the two DMA completion events and the three-edge synchronizer latency show only in the bench's scenarios. So do the override of a software write by a fault in the same cycle, and the interaction of random configuration changes with the sticky flags, which a reference model tracks.

// File: rtl/spi_irq_pkg.sv
// Package: shared constants and configuration type for the SPI
// interrupt/mode-fault controller. Assumes a 4-bit status vector.
package spi_irq_pkg;
    localparam int ST_W      = 4;
    localparam int ST_FAULT  = 0;
    localparam int ST_UNDER  = 1;
    localparam int ST_OVER   = 2;
    localparam int ST_DONE   = 3;

    typedef struct packed {
        logic dma_en;
        logic xfer_irq_en;
        logic done_sel;
        logic err_irq_en;
        logic dir_rx;
        logic fault_det_en;
        logic irq_gate;
    } irq_cfg_t;
endpackage

// File: rtl/spi_ss_sync.sv
// Module: multi-stage synchronizer for an asynchronous level.
// Assumes STAGES >= 2; every stage resets to RST_VAL.
module spi_ss_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] shreg;

    // Shift the asynchronous level through the stage chain.
    always_ff @(posedge clk) begin
        if (!rst_n) shreg <= {STAGES{RST_VAL}};
        else        shreg <= {shreg[STAGES-2:0], d_async};
    end

    assign q_sync = shreg[STAGES-1];
endmodule

// File: rtl/spi_sticky_flags.sv
// Module: bank of sticky status bits with write-one-to-clear.
// Assumes set and clear are single-cycle strobes; set beats clear.
// Also exposes the next-state vector for same-edge consumers.
module spi_sticky_flags #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] flag_nxt,
    output logic [W-1:0] flag_q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        // Next value of one flag: set wins, else clear, else hold.
        always_comb begin
            if (set_i[i])      flag_nxt[i] = 1'b1;
            else if (clr_i[i]) flag_nxt[i] = 1'b0;
            else               flag_nxt[i] = flag_q[i];
        end

        // Register one flag.
        always_ff @(posedge clk) begin
            if (!rst_n) flag_q[i] <= 1'b0;
            else        flag_q[i] <= flag_nxt[i];
        end
    end
endmodule

// File: rtl/spi_mode_ctrl.sv
// Module: master/slave mode bit and multimaster fault detection.
// Assumes ss_sync_n is already synchronized. A fault on an edge
// overrides any software write on that edge and forces slave.
module spi_mode_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic fault_det_en,
    input  logic ss_sync_n,
    input  logic sw_wr,
    input  logic sw_val,
    output logic fault_hit,
    output logic master_q
);
    // Detect another driver pulling select low while master.
    always_comb fault_hit = fault_det_en & master_q & ~ss_sync_n;

    // Update the mode bit: fault first, then software write.
    always_ff @(posedge clk) begin
        if (!rst_n)         master_q <= 1'b0;
        else if (fault_hit) master_q <= 1'b0;
        else if (sw_wr)     master_q <= sw_val;
    end
endmodule

// File: rtl/spi_irq_select.sv
// Module: interrupt source selection and output register.
// Assumes flags are the next-state sticky flags so that the
// registered interrupt rises on the same edge as the flag.
module spi_irq_select
    import spi_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  irq_cfg_t        cfg,
    input  logic [ST_W-1:0] flags,
    input  logic            rx_ne,
    input  logic            tx_nf,
    output logic            irq_q
);
    logic xfer_src;
    logic err_src;
    logic dma_src;
    logic core_src;
    logic irq_nxt;

    // Transfer-done source in DMA mode.
    always_comb xfer_src = cfg.xfer_irq_en & flags[ST_DONE];

    // Error source: fault always, under/overflow qualified by direction.
    always_comb err_src = cfg.err_irq_en &
                          (flags[ST_FAULT] |
                           (~cfg.dir_rx & flags[ST_UNDER]) |
                           ( cfg.dir_rx & flags[ST_OVER]));

    // Combine sources per transfer mode.
    always_comb begin
        dma_src  = xfer_src | err_src;
        core_src = rx_ne | tx_nf;
        irq_nxt  = cfg.irq_gate & (cfg.dma_en ? dma_src : core_src);
    end

    // Register the interrupt line.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= irq_nxt;
    end
endmodule

// File: rtl/spi_irq_fault_ctrl.sv
// Module: top of the SPI interrupt and mode-fault controller.
// Assumes event inputs are single-cycle pulses synchronous to clk;
// ss_n_in is asynchronous and synchronized here.
module spi_irq_fault_ctrl
    import spi_irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_dma_en,
    input  logic            cfg_xfer_irq_en,
    input  logic            cfg_done_sel,
    input  logic            cfg_err_irq_en,
    input  logic            cfg_dir_rx,
    input  logic            cfg_fault_det_en,
    input  logic            cfg_irq_gate,
    input  logic            dma_count_zero,
    input  logic            dma_ext_done,
    input  logic            rx_not_empty,
    input  logic            tx_not_full,
    input  logic            tx_underflow,
    input  logic            rx_overflow,
    input  logic            ss_n_in,
    input  logic            sw_wr_master,
    input  logic            sw_master_val,
    input  logic [ST_W-1:0] sw_clr,
    output logic            irq_o,
    output logic [ST_W-1:0] status_o,
    output logic            master_o
);
    irq_cfg_t        cfg;
    logic            ss_sync_n;
    logic            fault_hit;
    logic            done_evt;
    logic [ST_W-1:0] flag_set;
    logic [ST_W-1:0] flag_nxt;

    // Gather configuration bits into one struct.
    always_comb begin
        cfg.dma_en       = cfg_dma_en;
        cfg.xfer_irq_en  = cfg_xfer_irq_en;
        cfg.done_sel     = cfg_done_sel;
        cfg.err_irq_en   = cfg_err_irq_en;
        cfg.dir_rx       = cfg_dir_rx;
        cfg.fault_det_en = cfg_fault_det_en;
        cfg.irq_gate     = cfg_irq_gate;
    end

    // Pick the DMA completion event named by the select bit.
    always_comb done_evt = cfg.dma_en &
                           (cfg.done_sel ? dma_ext_done : dma_count_zero);

    // Map events onto status bit positions.
    always_comb begin
        flag_set           = '0;
        flag_set[ST_FAULT] = fault_hit;
        flag_set[ST_UNDER] = tx_underflow;
        flag_set[ST_OVER]  = rx_overflow;
        flag_set[ST_DONE]  = done_evt;
    end

    spi_ss_sync #(
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (ss_n_in),
        .q_sync  (ss_sync_n)
    );

    spi_mode_ctrl u_mode (
        .clk          (clk),
        .rst_n        (rst_n),
        .fault_det_en (cfg.fault_det_en),
        .ss_sync_n    (ss_sync_n),
        .sw_wr        (sw_wr_master),
        .sw_val       (sw_master_val),
        .fault_hit    (fault_hit),
        .master_q     (master_o)
    );

    spi_sticky_flags #(
        .W (ST_W)
    ) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (flag_set),
        .clr_i    (sw_clr),
        .flag_nxt (flag_nxt),
        .flag_q   (status_o)
    );

    spi_irq_select u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .cfg   (cfg),
        .flags (flag_nxt),
        .rx_ne (rx_not_empty),
        .tx_nf (tx_not_full),
        .irq_q (irq_o)
    );
endmodule

// File: rtl/spi_irq_fault_ctrl_chk.sv
// Module: property checker for spi_irq_fault_ctrl, bound to the top.
// Assumes synchronous active-low reset.
module spi_irq_fault_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_dma_en,
    input logic       cfg_irq_gate,
    input logic       rx_not_empty,
    input logic       tx_not_full,
    input logic [3:0] sw_clr,
    input logic       irq_o,
    input logic [3:0] status_o,
    input logic       master_o
);
    // A fault flag only rises while the port was master (R8).
    assert_fault_needs_master_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_o[0]) |-> $past(master_o));

    // On the fault edge the port is already slave (R11).
    assert_fault_forces_slave_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_o[0]) |-> !master_o);

    // A set, uncleared flag stays set (R10).
    assert_flags_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (|(status_o & ~sw_clr)) |=> ((status_o & $past(status_o & ~sw_clr)) == $past(status_o & ~sw_clr)));

    // Closed gate silences the interrupt next cycle (R12).
    assert_gate_blocks_irq_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_irq_gate |=> !irq_o);

    // Core mode buffer request raises the interrupt next cycle (R2).
    assert_core_request_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_dma_en && cfg_irq_gate && (rx_not_empty || tx_not_full)) |=> irq_o);
endmodule

bind spi_irq_fault_ctrl spi_irq_fault_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_dma_en   (cfg_dma_en),
    .cfg_irq_gate (cfg_irq_gate),
    .rx_not_empty (rx_not_empty),
    .tx_not_full  (tx_not_full),
    .sw_clr       (sw_clr),
    .irq_o        (irq_o),
    .status_o     (status_o),
    .master_o     (master_o)
);

// File: tb/sim_spi_irq_fault_ctrl.sv
module sim_spi_irq_fault_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_dma_en = 0, cfg_xfer_irq_en = 0, cfg_done_sel = 0, cfg_err_irq_en = 0;
    logic cfg_dir_rx = 0, cfg_fault_det_en = 0, cfg_irq_gate = 0;
    logic dma_count_zero = 0, dma_ext_done = 0, rx_not_empty = 0, tx_not_full = 0;
    logic tx_underflow = 0, rx_overflow = 0, ss_n_in = 1, sw_wr_master = 0, sw_master_val = 0;
    logic [3:0] sw_clr = 0;
    logic irq_o, master_o;
    logic [3:0] status_o;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    spi_irq_fault_ctrl u0 (.*);

    // Reference model, updated on each rising edge from requirement text.
    logic [3:0] m_st;
    logic m_master, m_irq, m_s1, m_s2;
    function automatic logic exp_irq(input logic [3:0] f);
        logic d;
        if (!cfg_irq_gate) return 1'b0;
        if (!cfg_dma_en) return rx_not_empty | tx_not_full;
        d = (cfg_xfer_irq_en & f[3]) |
            (cfg_err_irq_en & (f[0] | (!cfg_dir_rx & f[1]) | (cfg_dir_rx & f[2])));
        return d;
    endfunction
    always @(posedge clk) begin
        logic flt;
        logic [3:0] nf;
        if (!rst_n) begin
            m_st = 0; m_master = 0; m_irq = 0; m_s1 = 1; m_s2 = 1;
        end else begin
            flt = cfg_fault_det_en & m_master & !m_s2;
            nf = m_st & ~sw_clr;
            if (flt) nf[0] = 1;
            if (tx_underflow) nf[1] = 1;
            if (rx_overflow) nf[2] = 1;
            if (cfg_dma_en && (cfg_done_sel ? dma_ext_done : dma_count_zero)) nf[3] = 1;
            m_irq = exp_irq(nf);
            m_st = nf;
            m_s2 = m_s1; m_s1 = ss_n_in;
            if (flt) m_master = 0; else if (sw_wr_master) m_master = sw_master_val;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_all();
        sw_clr = 4'hF; tick(1); sw_clr = 0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        tick(3); rst_n = 1; tick(1);
        // R1 reset state
        chk("R1 irq", irq_o, 0); chk("R1 status", status_o, 0); chk("R1 master", master_o, 0);

        // R2 core mode follows buffer levels
        cfg_irq_gate = 1; rx_not_empty = 1; tick(1);
        chk("R2 rx", irq_o, 1);
        rx_not_empty = 0; tx_not_full = 1; tick(1);
        chk("R2 tx", irq_o, 1);
        tx_not_full = 0; tick(1);
        chk("R2 idle", irq_o, 0);

        // R3 core mode errors recorded, no interrupt
        cfg_err_irq_en = 1; tx_underflow = 1; tick(1); tx_underflow = 0;
        chk("R3 status", status_o, 4'b0010); chk("R3 irq", irq_o, 0);
        clear_all(); chk("R10 cleared", status_o, 0);
        cfg_err_irq_en = 0;

        // R4 count-zero selected
        cfg_dma_en = 1; cfg_xfer_irq_en = 1; cfg_done_sel = 0;
        dma_ext_done = 1; tick(1); dma_ext_done = 0;
        chk("R4 ext ignored", {irq_o, status_o[3]}, 0);
        dma_count_zero = 1; tick(1); dma_count_zero = 0;
        chk("R4 cnt irq", {irq_o, status_o[3]}, 2'b11);
        tick(2); chk("R10 held", status_o[3], 1);
        clear_all(); chk("R4 cleared irq", irq_o, 0);

        // R5 external-done selected
        cfg_done_sel = 1;
        dma_count_zero = 1; tick(1); dma_count_zero = 0;
        chk("R5 cnt ignored", {irq_o, status_o[3]}, 0);
        dma_ext_done = 1; tick(1); dma_ext_done = 0;
        chk("R5 ext irq", {irq_o, status_o[3]}, 2'b11);
        clear_all(); cfg_xfer_irq_en = 0;

        // R6 underflow qualified by transmit direction
        cfg_err_irq_en = 1; cfg_dir_rx = 1;
        tx_underflow = 1; tick(1); tx_underflow = 0;
        chk("R6 rx dir no irq", {irq_o, status_o[1]}, 2'b01);
        clear_all();
        cfg_dir_rx = 0; tx_underflow = 1; tick(1); tx_underflow = 0;
        chk("R6 tx dir irq", irq_o, 1);
        clear_all();

        // R7 overflow qualified by receive direction
        rx_overflow = 1; tick(1); rx_overflow = 0;
        chk("R7 tx dir no irq", {irq_o, status_o[2]}, 2'b01);
        clear_all();
        cfg_dir_rx = 1; rx_overflow = 1; tick(1); rx_overflow = 0;
        chk("R7 rx dir irq", irq_o, 1);
        clear_all();

        // R12 gate holds interrupt off, flags kept
        cfg_irq_gate = 0; rx_overflow = 1; tick(1); rx_overflow = 0;
        chk("R12 gated", {irq_o, status_o[2]}, 2'b01);
        cfg_irq_gate = 1; tick(1);
        chk("R12 reopened", irq_o, 1);
        // R10 set wins over clear
        rx_overflow = 1; sw_clr = 4'b0100; tick(1); rx_overflow = 0; sw_clr = 0;
        chk("R10 set wins", status_o[2], 1);
        clear_all();

        // R11 software write, R8 fault detection and latency
        sw_wr_master = 1; sw_master_val = 1; tick(1); sw_wr_master = 0;
        chk("R11 write", master_o, 1);
        cfg_fault_det_en = 1; ss_n_in = 0; tick(2);
        chk("R8 not yet", {master_o, status_o[0]}, 2'b10);
        tick(1);
        chk("R8 fault", {irq_o, master_o, status_o[0]}, 3'b101);
        ss_n_in = 1; tick(3); clear_all();
        sw_wr_master = 1; tick(1); sw_wr_master = 0;
        ss_n_in = 0; tick(2);
        sw_wr_master = 1; sw_master_val = 1; tick(1); sw_wr_master = 0;
        chk("R11 fault overrides", {master_o, status_o[0]}, 2'b01);
        ss_n_in = 1; tick(3); clear_all();

        // R9 detection disabled
        cfg_fault_det_en = 0; sw_wr_master = 1; tick(1); sw_wr_master = 0;
        ss_n_in = 0; tick(4);
        chk("R9 no fault", {master_o, status_o[0]}, 2'b10);
        ss_n_in = 1; tick(2);

        // Random phase against the model (R2 R4 R6 R7 R10 R11 R12)
        void'($urandom(32'h5A17));
        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(0, 31) == 0) begin
                {cfg_dma_en, cfg_xfer_irq_en, cfg_done_sel, cfg_err_irq_en,
                 cfg_dir_rx, cfg_fault_det_en} = 6'($urandom);
                cfg_irq_gate = ($urandom_range(0, 7) != 0);
            end
            dma_count_zero = ($urandom_range(0, 7) == 0);
            dma_ext_done   = ($urandom_range(0, 7) == 0);
            tx_underflow   = ($urandom_range(0, 9) == 0);
            rx_overflow    = ($urandom_range(0, 9) == 0);
            rx_not_empty   = ($urandom_range(0, 3) == 0);
            tx_not_full    = ($urandom_range(0, 3) == 0);
            if ($urandom_range(0, 15) == 0) ss_n_in = ~ss_n_in;
            sw_wr_master   = ($urandom_range(0, 11) == 0);
            sw_master_val  = ($urandom_range(0, 3) != 0);
            sw_clr         = ($urandom_range(0, 5) == 0) ? 4'($urandom) : 4'h0;
            tick(1);
            chk(cfg_dma_en ? "R4 R6 R7 R12 irq" : "R2 R12 irq", irq_o, m_irq);
            chk("R10 status", status_o, m_st);
            chk("R11 master", master_o, m_master);
        end

        done = 1;
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule